// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a synchronous host and an asynchronous 4M x 4 EDO DRAM. The host issues one word access at a time over a valid/ready port. Each access carries a 22-bit word address, a write flag and 4 bits of write data. The controller splits the address into a row and a column and drives both over one multiplexed address bus. It activates the row with RAS#, then strobes the column with CAS#. Reads come back on a 4-bit data port with a one-cycle done strobe.

After an access the row stays open. A later access to the same row is served as an EDO page-mode column cycle, with CAS# toggling while RAS# stays low. An access to a different row first raises RAS# and waits out the precharge time. All writes are early writes: WE# goes low before CAS# falls, so the device outputs stay in High-Z and the controller may drive DQ.

An interval timer requests CAS#-before-RAS# refresh so that one refresh is issued per row within each refresh period. A pending refresh closes any open row and runs before the next host request is accepted. Every analog timing limit is turned into whole clock cycles from a clock-period parameter. A parameter selects the 11/11 or 12/10 row/column split.

Top module: `edo_page_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, ras_n_o, cas_n_o, we_n_o and oe_n_o are high, dq_oe_o and rd_done_o are low, and req_ready_o is high.
- R2: Row and column come from the word address as row = addr[21:COL_BITS] and column = addr[COL_BITS-1:0]. COL_BITS is 10 when REFRESH_4K=1 and 11 otherwise. At each RAS# fall that opens a row, ma_o carries the row. At each CAS# fall that occurs while RAS# is low, ma_o carries the column, and every ma_o bit at or above COL_BITS is 0.
- R3: A write is always an early write. WE# falls at least one cycle before CAS# falls and stays low while CAS# is low. OE# stays high while DQ is driven. dq_o carries the write data when CAS# falls.
- R4: A read ends with a one-cycle rd_done_o pulse. rd_data_o then holds the value stored at that address, or 0 for a word that was never written.
- R5: An access to the row that is already open causes no RAS# activation. It issues only a column cycle.
- R6: An access to a different row first raises RAS#. RAS# then stays high for at least ceil((tRC - tRAC)/CLK_PERIOD_NS) cycles before it falls again.
- R7: Each CAS# low pulse lasts at least ceil(tCAS/CLK_PERIOD_NS) cycles. A read CAS# pulse ends no earlier than tCAC after the CAS# fall and tRAC after the RAS# fall.
- R8: Refresh uses CAS# low with RAS# high and WE# high for one cycle, then RAS# low. One refresh is issued per REFRESH_PERIOD_NS / 2^ROW_BITS interval.
- R9: req_ready_o is low from the cycle after a request is accepted until the controller is idle again, and also while a refresh is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller accepts a request this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Word address, row in the upper bits |
| req_wdata_i | input | 4 | Write data |
| rd_done_o | output | 1 | Read data valid, one-cycle pulse |
| rd_data_o | output | 4 | Read data |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| ma_o | output | 12 | Multiplexed row/column address |
| dq_o | output | 4 | Data driven toward the DRAM |
| dq_oe_o | output | 1 | DQ driver enable |
| dq_i | input | 4 | Data from the DRAM |

## Verification
The bench builds the controller with REFRESH_4K=1 and REFRESH_PERIOD_NS set so that the refresh interval is 200 cycles. The 12/10 split puts a live row bit on ma_o[11]. With that split, a column strobe with nonzero upper address bits would be seen by the memory model. The short interval brings about ten refreshes into a 2000-cycle idle window, so the refresh rate can be counted. It also lets the page-hit test start right after a refresh and finish before the next one. The timing limits keep their -6 defaults at a 10 ns clock, so the cycle counts are small and the model's nanosecond pulse-width checks are exercised directly.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RSET, ST_ROW, ST_CSET, ST_CAS, ST_PRE, ST_RCAS, ST_RRAS
  } edo_state_e;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_addr_map.sv
module edo_addr_map #(
  parameter int ADDR_W   = 22,
  parameter int ROW_BITS = 11,
  parameter int COL_BITS = 11,
  parameter int MA_W     = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MA_W-1:0]   row_ma_o,
  output logic [MA_W-1:0]   col_ma_o
);
  logic [ROW_BITS-1:0] row;
  logic [COL_BITS-1:0] col;
  assign row = addr_i[ADDR_W-1:COL_BITS];
  assign col = addr_i[COL_BITS-1:0];
  // unused upper pins stay low during the column phase
  assign row_ma_o = MA_W'(row);
  assign col_ma_o = MA_W'(col);
endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(INTERVAL - 1);
      pend_o <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        cnt_q  <= CNT_W'(INTERVAL - 1);
        pend_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (ack_i) pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int  ADDR_W            = 22,
  parameter int  DQ_W              = 4,
  parameter bit  REFRESH_4K        = 1'b0,
  parameter int  CLK_PERIOD_NS     = 10,
  parameter int  T_RC_NS           = 104,
  parameter int  T_RAC_NS          = 60,
  parameter int  T_PC_NS           = 25,
  parameter int  T_AA_NS           = 30,
  parameter int  T_CAC_NS          = 15,
  parameter int  T_CAS_NS          = 10,
  parameter int  REFRESH_PERIOD_NS = 64_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  output logic              rd_done_o,
  output logic [DQ_W-1:0]   rd_data_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [11:0]       ma_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  input  logic [DQ_W-1:0]   dq_i
);
  localparam int ROW_BITS = REFRESH_4K ? 12 : 11;
  localparam int COL_BITS = REFRESH_4K ? 10 : 11;
  localparam int MA_W     = 12;
  localparam int ROWS     = 1 << ROW_BITS;
  // read CAS# low: access from CAS# plus one sampling cycle, and tAA after setup
  localparam int CAS_RD   = max2(max2(cdiv(T_CAC_NS, CLK_PERIOD_NS) + 1, cdiv(T_AA_NS, CLK_PERIOD_NS)),
                                 max2(cdiv(T_PC_NS, CLK_PERIOD_NS) - 1, cdiv(T_CAS_NS, CLK_PERIOD_NS)));
  localparam int CAS_WR   = max2(cdiv(T_CAS_NS, CLK_PERIOD_NS), cdiv(T_PC_NS, CLK_PERIOD_NS) - 1);
  localparam int RCD_CYC  = max2(1, cdiv(T_RAC_NS, CLK_PERIOD_NS) - CAS_RD);
  localparam int RP_CYC   = max2(1, cdiv(T_RC_NS - T_RAC_NS, CLK_PERIOD_NS));
  localparam int RREF_CYC = max2(1, cdiv(T_RAC_NS, CLK_PERIOD_NS));
  localparam int CAS_MIN  = cdiv(T_CAS_NS, CLK_PERIOD_NS);
  localparam int REF_INT  = max2(1, REFRESH_PERIOD_NS / ROWS / CLK_PERIOD_NS);

  edo_state_e          state_q;
  logic [7:0]          cnt_q;
  logic                row_open_q, req_held_q;
  logic [ROW_BITS-1:0] open_row_q;
  logic                req_we_q;
  logic [ADDR_W-1:0]   req_addr_q;
  logic [DQ_W-1:0]     req_wd_q;
  logic [MA_W-1:0]     row_ma, col_ma;
  logic                ref_pend, ref_ack, accept, hit;

  edo_addr_map #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .MA_W(MA_W)
  ) u_map (
    .addr_i(req_addr_q), .row_ma_o(row_ma), .col_ma_o(col_ma)
  );

  edo_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .pend_o(ref_pend)
  );

  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend;
  assign accept      = req_valid_i && req_ready_o;
  assign ref_ack     = (state_q == ST_IDLE) && ref_pend && !row_open_q;
  assign hit         = row_open_q && (req_addr_i[ADDR_W-1:COL_BITS] == open_row_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      row_open_q <= 1'b0;
      req_held_q <= 1'b0;
      open_row_q <= '0;
      req_we_q   <= 1'b0;
      req_addr_q <= '0;
      req_wd_q   <= '0;
      ras_n_o    <= 1'b1;
      cas_n_o    <= 1'b1;
      we_n_o     <= 1'b1;
      oe_n_o     <= 1'b1;
      ma_o       <= '0;
      dq_o       <= '0;
      dq_oe_o    <= 1'b0;
      rd_data_o  <= '0;
      rd_done_o  <= 1'b0;
    end else begin
      rd_done_o <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (ref_pend) begin
            if (row_open_q) begin
              ras_n_o    <= 1'b1;
              row_open_q <= 1'b0;
              cnt_q      <= 8'(RP_CYC - 1);
              state_q    <= ST_PRE;
            end else begin
              cas_n_o <= 1'b0;
              state_q <= ST_RCAS;
            end
          end else if (accept) begin
            req_we_q   <= req_we_i;
            req_addr_q <= req_addr_i;
            req_wd_q   <= req_wdata_i;
            if (hit) begin
              state_q <= ST_CSET;
            end else if (row_open_q) begin
              ras_n_o    <= 1'b1;
              row_open_q <= 1'b0;
              req_held_q <= 1'b1;
              cnt_q      <= 8'(RP_CYC - 1);
              state_q    <= ST_PRE;
            end else begin
              state_q <= ST_RSET;
            end
          end
        end
        ST_RSET: begin
          ma_o       <= row_ma;
          state_q    <= ST_ROW;
        end
        ST_ROW: begin
          if (ras_n_o) begin
            ras_n_o    <= 1'b0;
            row_open_q <= 1'b1;
            open_row_q <= req_addr_q[ADDR_W-1:COL_BITS];
            cnt_q      <= 8'(RCD_CYC - 1);
          end else if (cnt_q == '0) begin
            state_q <= ST_CSET;
          end
        end
        ST_CSET: begin
          ma_o    <= col_ma;
          we_n_o  <= !req_we_q;
          dq_o    <= req_wd_q;
          dq_oe_o <= req_we_q;
          state_q <= ST_CAS;
          cnt_q   <= 8'(req_we_q ? CAS_WR : CAS_RD);
        end
        ST_CAS: begin
          if (!cas_n_o && cnt_q == 8'd1) begin
            cas_n_o <= 1'b1;
            oe_n_o  <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
            if (!req_we_q) begin
              rd_data_o <= dq_i;
              rd_done_o <= 1'b1;
            end
            state_q <= ST_IDLE;
          end else if (cas_n_o) begin
            cas_n_o <= 1'b0;
            oe_n_o  <= req_we_q;
            cnt_q   <= cnt_q;
          end
        end
        ST_PRE: begin
          if (cnt_q == '0) begin
            state_q    <= req_held_q ? ST_RSET : ST_IDLE;
            req_held_q <= 1'b0;
          end
        end
        ST_RCAS: begin
          ras_n_o <= 1'b0;
          cnt_q   <= 8'(RREF_CYC - 1);
          state_q <= ST_RRAS;
        end
        ST_RRAS: begin
          if (cnt_q == '0) begin
            ras_n_o <= 1'b1;
            cas_n_o <= 1'b1;
            cnt_q   <= 8'(RP_CYC - 1);
            state_q <= ST_PRE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int RP_MIN   = 5,
  parameter int CAS_MIN  = 1,
  parameter int COL_BITS = 11
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ras_n_o,
  input logic        cas_n_o,
  input logic        we_n_o,
  input logic        oe_n_o,
  input logic        dq_oe_o,
  input logic        rd_done_o,
  input logic        req_ready_o,
  input logic [11:0] ma_o
);
  logic [7:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 8'hff;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= ras_n_o ? ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= !cas_n_o ? ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 1'b1) : '0;
    end
  end

  assert_col_upper_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !ras_n_o) |-> ((ma_o >> COL_BITS) == '0));
  assert_early_we_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !we_n_o) |-> $past(!we_n_o));
  assert_we_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && $past(!cas_n_o)) |-> $stable(we_n_o));
  assert_oe_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_n_o);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= 8'(RP_MIN)));
  assert_cas_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> (lo_cnt >= 8'(CAS_MIN)));
  assert_cbr_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> ($past(!cas_n_o) && we_n_o));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cas_n_o && dq_oe_o == 1'b0));
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
  .RP_MIN(RP_CYC), .CAS_MIN(CAS_MIN), .COL_BITS(COL_BITS)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .we_n_o(we_n_o), .oe_n_o(oe_n_o), .dq_oe_o(dq_oe_o), .rd_done_o(rd_done_o),
  .req_ready_o(req_ready_o), .ma_o(ma_o)
);

// File: tb/edo_page_ctrl_tb_top.sv
module edo_page_ctrl_tb_top;
  localparam int CLK_NS = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_we_i = 1'b0;
  logic [21:0] req_addr_i = '0;
  logic [3:0]  req_wdata_i = '0;
  logic        rd_done_o;
  logic [3:0]  rd_data_o;
  logic        ras_n_o, cas_n_o, we_n_o, oe_n_o, dq_oe_o;
  logic [11:0] ma_o;
  logic [3:0]  dq_o;
  logic [3:0]  m_dq = '0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  edo_page_ctrl #(
    .REFRESH_4K(1'b1), .CLK_PERIOD_NS(CLK_NS), .REFRESH_PERIOD_NS(4096 * 2000)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_done_o(rd_done_o), .rd_data_o(rd_data_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .oe_n_o(oe_n_o), .ma_o(ma_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .dq_i(m_dq)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural DRAM: latches multiplexed address, checks pulse widths in ns
  logic [3:0] mem [int];
  logic [11:0] m_row = '0;
  logic [9:0]  m_col = '0;
  time ras_rise_t = 0, ras_fall_t = 0, cas_fall_t = 0, we_fall_t = 0;
  int act_cnt = 0, ref_cnt = 0, r2_err = 0, r3_err = 0, r6_err = 0, r7_err = 0, r8_err = 0;

  always @(posedge ras_n_o) ras_rise_t = $time;
  always @(negedge we_n_o)  we_fall_t  = $time;
  always @(negedge ras_n_o) begin
    if (cas_n_o) begin
      if ($time - ras_rise_t < 44) r6_err++;
      m_row = ma_o;
      act_cnt++;
    end else begin
      ref_cnt++;
      if (!we_n_o) r8_err++;
    end
    ras_fall_t = $time;
  end
  always @(negedge cas_n_o) begin
    if (!ras_n_o) begin
      cas_fall_t = $time;
      if (ma_o[11:10] != 2'b00) r2_err++;
      m_col = ma_o[9:0];
      if (!we_n_o) begin
        if (we_fall_t >= $time) r3_err++;
        if (!dq_oe_o || !oe_n_o) r3_err++;
        mem[{m_row, m_col}] = dq_o;
      end else begin
        m_dq = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 4'h0;
      end
    end
  end
  always @(posedge cas_n_o) begin
    if (!ras_n_o) begin
      if ($time - cas_fall_t < 10) r7_err++;
      if (we_n_o && ($time - cas_fall_t < 15 || $time - ras_fall_t < 60 ||
                     $time - cas_fall_t + CLK_NS < 30)) r7_err++;
    end
  end

  logic [3:0] sb [int];

  task automatic do_req(input bit we, input logic [21:0] a, input logic [3:0] d,
                        output logic [3:0] rd, input bit chk_busy);
    int guard = 0;
    @(negedge clk_i);
    while (!req_ready_o && guard < 1000) begin @(negedge clk_i); guard++; end
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (chk_busy) check(!req_ready_o, "R9 ready low while busy", req_ready_o, 0);
    if (we) sb[int'(a)] = d;
    rd = 4'h0;
    if (!we) begin
      guard = 0;
      while (!rd_done_o && guard < 1000) begin @(negedge clk_i); guard++; end
      rd = rd_data_o;
      @(negedge clk_i);
      check(!rd_done_o, "R4 done is one cycle", rd_done_o, 0);
    end
  endtask

  typedef struct packed { logic we; logic [21:0] addr; logic [3:0] data; } vec_t;
  localparam vec_t VECS [12] = '{
    '{1'b1, 22'h000005, 4'hA}, '{1'b1, 22'h000006, 4'h3},
    '{1'b0, 22'h000005, 4'hA}, '{1'b0, 22'h000006, 4'h3},
    '{1'b1, 22'h3FF3FF, 4'hF}, '{1'b0, 22'h000005, 4'hA},
    '{1'b1, 22'h000405, 4'h6}, '{1'b0, 22'h3FF3FF, 4'hF},
    '{1'b0, 22'h000405, 4'h6}, '{1'b0, 22'h000005, 4'hA},
    '{1'b1, 22'h000005, 4'hC}, '{1'b0, 22'h000005, 4'hC}
  };

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] rd;
    logic [15:0] lfsr;
    int a0, r0;
    // R1 reset state
    repeat (6) @(negedge clk_i);
    check(ras_n_o && cas_n_o && we_n_o && oe_n_o && !dq_oe_o && !rd_done_o,
          "R1 strobes idle in reset", {ras_n_o, cas_n_o, we_n_o, oe_n_o}, 15);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && ras_n_o && cas_n_o, "R1 ready after reset", req_ready_o, 1);

    // R2 R4 vector table
    for (int i = 0; i < 12; i++) begin
      do_req(VECS[i].we, VECS[i].addr, VECS[i].data, rd, i == 0);
      if (!VECS[i].we) check(rd == VECS[i].data, "R4 table read", rd, VECS[i].data);
    end

    // R4 random mix over a few rows
    lfsr = 16'hACE1;
    for (int i = 0; i < 24; i++) begin
      logic [21:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:1])
        2'd0: a = 22'h000010;
        2'd1: a = 22'h000011;
        2'd2: a = 22'h000410;
        default: a = 22'h3FF000;
      endcase
      do_req(lfsr[0], a, lfsr[7:4], rd, 1'b0);
      if (!lfsr[0]) check(rd == (sb.exists(int'(a)) ? sb[int'(a)] : 4'h0),
                          "R4 random read", rd, sb.exists(int'(a)) ? sb[int'(a)] : 0);
    end

    // R5 page hit right after a refresh
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    a0 = act_cnt;
    do_req(1'b1, 22'h000801, 4'h9, rd, 1'b0);
    do_req(1'b0, 22'h000802, 4'h0, rd, 1'b0);
    check(act_cnt == a0 + 1, "R5 page hit without new activation", act_cnt - a0, 1);
    check(rd == 4'h0, "R4 unwritten word reads zero", rd, 0);
    do_req(1'b0, 22'h000801, 4'h0, rd, 1'b0);
    check(rd == 4'h9 && act_cnt == a0 + 1, "R5 page hit read", rd, 9);
    // R6 row miss
    do_req(1'b0, 22'h000C01, 4'h0, rd, 1'b0);
    check(act_cnt == a0 + 2, "R6 row miss activates once", act_cnt - a0, 2);

    // R8 refresh rate over 2000 idle cycles, interval 200
    r0 = ref_cnt;
    repeat (2000) @(negedge clk_i);
    check(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R8 refresh count", ref_cnt - r0, 10);
    check(r8_err == 0, "R8 CBR with WE high", r8_err, 0);
    check(r2_err == 0, "R2 column upper pins low", r2_err, 0);
    check(r3_err == 0, "R3 early write", r3_err, 0);
    check(r6_err == 0, "R6 precharge time", r6_err, 0);
    check(r7_err == 0, "R7 CAS pulse and access", r7_err, 0);
    finish_run();
  end
endmodule